// File: doc/BRIEF.md
# Interrupt Claim and Complete Arbiter

This block is the decision core of a platform-level interrupt controller. It watches a set of level-sensitive interrupt sources and serves a number of contexts, where a context is one receiver of interrupts, such as one privilege level of one processor. Each context owns an enable mask over the sources and a priority threshold. Each source has its own priority. The block raises one interrupt line per context while that context has work that clears its threshold.

A context takes work with a claim strobe. The combinational claim ID shows which source the claim would take. The block scans the sources from the lowest number upward and picks the first one that qualifies, whatever its priority compared with the others. A successful claim marks the source as claimed, which hides it from every context until a complete strobe that carries its ID releases it. Source 0 is reserved, so an ID of 0 always means that nothing qualifies.

Top module: `intc_claim_core`

## Requirements
- R1: Source s qualifies for context c only when its pending bit is 1, its claimed bit is 0 and bit c*NUM_SRC+s of `ctx_enable` is 1.
- R2: `irq[c]` is a register that is 1 exactly when, in the previous cycle, some source qualified for context c with a priority (`src_prio[s*PRIO_W +: PRIO_W]`) strictly greater than the threshold `ctx_thresh[c*PRIO_W +: PRIO_W]`. It updates on every edge, so threshold changes and completions show up one cycle later.
- R3: `claim_id[c*ID_W +: ID_W]` is the lowest-numbered source that qualifies for context c with priority above its threshold, whatever the priorities of higher-numbered sources. It is 0 when no source does.
- R4: A claim (`claim_req[c]` high for one cycle) with a nonzero claim ID sets that source's claimed bit, which hides it from every context from the next cycle on.
- R5: A claim whose claim ID is 0 changes no claimed bit.
- R6: A source's pending bit follows its input `src_level[s]`. It is 0 in the cycle after the input is low. It is also cleared in the cycle after a claim takes the source, and it is refilled from the input after that.
- R7: A complete (`complete_req[c]` high with `complete_id[c*ID_W +: ID_W]`) clears the claimed bit of that source when the ID is below NUM_SRC. A larger ID has no effect.
- R8: When a claim and a complete refer to the same source in the same cycle, the complete wins and the source ends unclaimed. The claim ID in that cycle reflects the state before the edge.
- R9: Source 0 is never pending, whatever the level of `src_level[0]`.
- R10: Reset (synchronous, active high) clears every pending and claimed bit and drives every `irq` line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Raw source levels |
| src_prio | input | NUM_SRC*PRIO_W | Priority of each source |
| ctx_enable | input | NUM_CTX*NUM_SRC | Enable mask of each context |
| ctx_thresh | input | NUM_CTX*PRIO_W | Threshold of each context |
| claim_req | input | NUM_CTX | Claim strobe of each context |
| complete_req | input | NUM_CTX | Complete strobe of each context |
| complete_id | input | NUM_CTX*ID_W | Source ID carried by each complete |
| irq | output | NUM_CTX | Registered interrupt line of each context |
| claim_id | output | NUM_CTX*ID_W | Combinational claim ID of each context |

## Verification
The bench builds the block with 12 sources, 2 contexts, 3-bit priorities and a scan group width of 4. The sources then span three scan groups, so lowest-first selection is tested across group boundaries. With these values the ID is 4 bits wide, so the out-of-range complete IDs 12 to 15 can be driven. The small size allows a full priority-by-threshold grid on every source and all 2048 enable masks over sources 1 to 11.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // ID width that can carry every source number plus at least one
  // out-of-range value, so "ID >= NUM_SRC" is expressible on the port.
  function automatic int id_width(input int n_src);
    return $clog2(n_src + 1);
  endfunction

  // Number of scan groups covering n_src sources.
  function automatic int group_count(input int n_src, input int grp_w);
    return (n_src + grp_w - 1) / grp_w;
  endfunction
endpackage

// File: rtl/intc_src_state.sv
// Pending and claimed state of all sources.
module intc_src_state #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [NUM_SRC-1:0] take_mask,
  input  logic [NUM_SRC-1:0] free_mask,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] claim_q
);
  // Source 0 is reserved: its bits never leave zero.
  localparam logic [NUM_SRC-1:0] LIVE = {{(NUM_SRC-1){1'b1}}, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      claim_q <= '0;
    end else begin
      pend_q  <= src_level & ~take_mask & LIVE;
      // complete wins over claim on the same source
      claim_q <= (claim_q | take_mask) & ~free_mask & LIVE;
    end
  end
endmodule

// File: rtl/intc_cmpl_decode.sv
// Turns the complete strobes of all contexts into one release mask.
module intc_cmpl_decode #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 4,
  parameter int ID_W    = 6
) (
  input  logic [NUM_CTX-1:0]      complete_req,
  input  logic [NUM_CTX*ID_W-1:0] complete_id,
  output logic [NUM_SRC-1:0]      free_mask
);
  always_comb begin
    free_mask = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        // IDs at or above NUM_SRC match no source and fall away here
        if (complete_req[c] && complete_id[c*ID_W +: ID_W] == ID_W'(s))
          free_mask[s] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_ctx_select.sv
// Qualification and lowest-index selection for one context.
module intc_ctx_select #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6,
  parameter int GRP_W   = 32
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC-1:0]        claimed,
  input  logic [NUM_SRC-1:0]        enable,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [PRIO_W-1:0]         thresh,
  output logic [ID_W-1:0]           cand_id,
  output logic                      cand_hit
);
  localparam int NUM_GRP = intc_pkg::group_count(NUM_SRC, GRP_W);
  localparam int PAD     = NUM_GRP * GRP_W;
  localparam int OFS_W   = $clog2(GRP_W);

  logic [PAD-1:0]     qual;
  logic [NUM_GRP-1:0] grp_any;
  logic [OFS_W-1:0]   grp_low [NUM_GRP];

  always_comb begin
    qual = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      qual[s] = pend[s] & ~claimed[s] & enable[s] &
                (src_prio[s*PRIO_W +: PRIO_W] > thresh);
    end
  end

  // first level: lowest set bit inside each group
  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) begin
      grp_low[g] = '0;
      grp_any[g] = |qual[g*GRP_W +: GRP_W];
      for (int b = GRP_W - 1; b >= 0; b--) begin
        if (qual[g*GRP_W + b]) grp_low[g] = OFS_W'(b);
      end
    end
  end

  // second level: lowest group that holds a candidate
  always_comb begin
    cand_id = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (grp_any[g]) cand_id = ID_W'(g * GRP_W + int'(grp_low[g]));
    end
    cand_hit = |grp_any;
  end
endmodule

// File: rtl/intc_claim_core.sv
module intc_claim_core #(
  parameter  int NUM_SRC = 32,
  parameter  int NUM_CTX = 4,
  parameter  int PRIO_W  = 3,
  parameter  int GRP_W   = 32,
  localparam int ID_W    = intc_pkg::id_width(NUM_SRC)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SRC-1:0]          src_level,
  input  logic [NUM_SRC*PRIO_W-1:0]   src_prio,
  input  logic [NUM_CTX*NUM_SRC-1:0]  ctx_enable,
  input  logic [NUM_CTX*PRIO_W-1:0]   ctx_thresh,
  input  logic [NUM_CTX-1:0]          claim_req,
  input  logic [NUM_CTX-1:0]          complete_req,
  input  logic [NUM_CTX*ID_W-1:0]     complete_id,
  output logic [NUM_CTX-1:0]          irq,
  output logic [NUM_CTX*ID_W-1:0]     claim_id
);
  logic [NUM_SRC-1:0]      pend_vec;
  logic [NUM_SRC-1:0]      claim_vec;
  logic [NUM_SRC-1:0]      take_mask;
  logic [NUM_SRC-1:0]      free_mask;
  logic [NUM_CTX-1:0]      ctx_hit;
  logic [NUM_CTX*ID_W-1:0] ctx_id;
  logic [NUM_CTX-1:0]      irq_q;

  intc_src_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk       (clk),
    .rst       (rst),
    .src_level (src_level),
    .take_mask (take_mask),
    .free_mask (free_mask),
    .pend_q    (pend_vec),
    .claim_q   (claim_vec)
  );

  intc_cmpl_decode #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ID_W(ID_W)) u_cmpl (
    .complete_req (complete_req),
    .complete_id  (complete_id),
    .free_mask    (free_mask)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    intc_ctx_select #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ID_W    (ID_W),
      .GRP_W   (GRP_W)
    ) u_sel (
      .pend     (pend_vec),
      .claimed  (claim_vec),
      .enable   (ctx_enable[c*NUM_SRC +: NUM_SRC]),
      .src_prio (src_prio),
      .thresh   (ctx_thresh[c*PRIO_W +: PRIO_W]),
      .cand_id  (ctx_id[c*ID_W +: ID_W]),
      .cand_hit (ctx_hit[c])
    );
  end

  // a claim that finds a candidate takes it
  always_comb begin
    take_mask = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (claim_req[c] && ctx_hit[c] && ctx_id[c*ID_W +: ID_W] == ID_W'(s))
          take_mask[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= ctx_hit;
  end

  assign irq      = irq_q;
  assign claim_id = ctx_id;
endmodule

// File: rtl/intc_claim_core_chk.sv
module intc_claim_core_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 4,
  parameter int ID_W    = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_SRC-1:0]      src_level,
  input logic [NUM_CTX-1:0]      claim_req,
  input logic [NUM_CTX*ID_W-1:0] claim_id,
  input logic [NUM_CTX-1:0]      complete_req,
  input logic [NUM_CTX*ID_W-1:0] complete_id,
  input logic [NUM_CTX-1:0]      irq,
  input logic [NUM_SRC-1:0]      pend_vec,
  input logic [NUM_SRC-1:0]      claim_vec
);
  logic live_q = 1'b0;
  logic claim_fire;

  always_ff @(posedge clk) live_q <= !rst;

  always_comb begin
    claim_fire = 1'b0;
    for (int c = 0; c < NUM_CTX; c++)
      if (claim_req[c] && claim_id[c*ID_W +: ID_W] != '0) claim_fire = 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (claim_vec == '0 && pend_vec == '0 && irq == '0));  // R10

  AST_SRC0_IDLE: assert property (@(posedge clk) disable iff (rst || !live_q)
    !pend_vec[0] && !claim_vec[0]);  // R9

  AST_PEND_DROPS: assert property (@(posedge clk) disable iff (rst || !live_q)
    1'b1 |=> (pend_vec & ~$past(src_level)) == '0);  // R6

  AST_QUIET_CLAIM: assert property (@(posedge clk) disable iff (rst || !live_q)
    (!claim_fire && complete_req == '0) |=> $stable(claim_vec));  // R5

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !live_q)
      irq[c] == $past(claim_id[c*ID_W +: ID_W] != '0));  // R2

    AST_ID_RANGE: assert property (@(posedge clk) disable iff (rst || !live_q)
      int'(claim_id[c*ID_W +: ID_W]) < NUM_SRC);  // R3

    AST_CLAIM_MARKS: assert property (@(posedge clk) disable iff (rst || !live_q)
      (claim_req[c] && claim_id[c*ID_W +: ID_W] != '0 && complete_req == '0)
      |=> claim_vec[$past(claim_id[c*ID_W +: ID_W])]);  // R4

    AST_COMPLETE_FREES: assert property (@(posedge clk) disable iff (rst || !live_q)
      (complete_req[c] && int'(complete_id[c*ID_W +: ID_W]) < NUM_SRC)
      |=> !claim_vec[$past(complete_id[c*ID_W +: ID_W])]);  // R7, R8
  end
endmodule

bind intc_claim_core intc_claim_core_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_CTX (NUM_CTX),
  .ID_W    (ID_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .src_level    (src_level),
  .claim_req    (claim_req),
  .claim_id     (claim_id),
  .complete_req (complete_req),
  .complete_id  (complete_id),
  .irq          (irq),
  .pend_vec     (pend_vec),
  .claim_vec    (claim_vec)
);

// File: tb/intc_claim_core_bench.sv
`timescale 1ns/1ps
module intc_claim_core_bench;
  localparam int N  = 12;
  localparam int C  = 2;
  localparam int P  = 3;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0]   lvl  = '0;
  logic [N*P-1:0] prio = '0;
  logic [C*N-1:0] en   = '0;
  logic [C*P-1:0] thr  = '0;
  logic [C-1:0]   creq = '0;
  logic [C-1:0]   dreq = '0;
  logic [C*IW-1:0] did = '0;
  logic [C-1:0]    irq;
  logic [C*IW-1:0] cid;

  bit m_cl [N];
  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  intc_claim_core #(.NUM_SRC(N), .NUM_CTX(C), .PRIO_W(P), .GRP_W(4)) u_intc_claim_core (
    .clk (clk), .rst (rst), .src_level (lvl), .src_prio (prio),
    .ctx_enable (en), .ctx_thresh (thr), .claim_req (creq),
    .complete_req (dreq), .complete_id (did), .irq (irq), .claim_id (cid)
  );

  function automatic int exp_id(int c);
    for (int s = 1; s < N; s++)
      if (lvl[s] && !m_cl[s] && en[c*N+s] && int'(prio[s*P +: P]) > int'(thr[c*P +: P]))
        return s;
    return 0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_ctx(int c, string tag);
    chk(tag, int'(cid[c*IW +: IW]), exp_id(c));
    chk(tag, int'(irq[c]), int'(exp_id(c) != 0));
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic claim(int c, string tag);
    int e;
    @(negedge clk);
    creq[c] = 1'b1;
    #1;
    e = exp_id(c);
    chk(tag, int'(cid[c*IW +: IW]), e);
    if (e != 0) m_cl[e] = 1'b1;
    @(negedge clk);
    creq[c] = 1'b0;
  endtask

  task automatic complete(int c, int id);
    @(negedge clk);
    dreq[c] = 1'b1;
    did[c*IW +: IW] = IW'(id);
    @(negedge clk);
    dreq[c] = 1'b0;
    if (id < N) m_cl[id] = 1'b0;
  endtask

  task automatic claim_complete(int c, int id, string tag);
    int e;
    @(negedge clk);
    creq[c] = 1'b1;
    dreq[c] = 1'b1;
    did[c*IW +: IW] = IW'(id);
    #1;
    e = exp_id(c);
    chk(tag, int'(cid[c*IW +: IW]), e);
    if (e != 0) m_cl[e] = 1'b1;
    if (id < N) m_cl[id] = 1'b0;
    @(negedge clk);
    creq[c] = 1'b0;
    dreq[c] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 irq in reset", int'(irq), 0);
    rst = 1'b0;
    foreach (m_cl[i]) m_cl[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    foreach (m_cl[i]) m_cl[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset irq", int'(irq), 0);
    chk("R10 reset claim id", int'(cid), 0);
    rst = 1'b0;
    settle();
    chk_ctx(0, "R10 idle after reset");

    // R2 R3: priority against threshold, one source at a time, every group
    for (int s = 1; s < N; s++) begin
      for (int p = 0; p < 8; p++) begin
        for (int t = 0; t < 8; t++) begin
          @(negedge clk);
          lvl = '0; lvl[s] = 1'b1;
          prio = '0; prio[s*P +: P] = P'(p);
          en = '0; en[s] = 1'b1;
          thr[0 +: P] = P'(t);
          settle();
          chk_ctx(0, "R2 strict threshold");
          chk_ctx(1, "R1 disabled context");
        end
      end
    end

    // R1 R3: all enable masks, lowest qualifying source wins
    @(negedge clk);
    lvl = {{(N-1){1'b1}}, 1'b0};
    for (int s = 0; s < N; s++) prio[s*P +: P] = P'((s * 5) % 8);
    thr = '0; thr[0 +: P] = P'(2);
    for (int k = 0; k < 2048; k++) begin
      @(negedge clk);
      en = '0; en[N-1:0] = N'(k << 1);
      settle();
      chk_ctx(0, "R3 lowest eligible");
    end

    // R9: source 0 alone never shows
    @(negedge clk);
    lvl = '0; lvl[0] = 1'b1;
    prio[0 +: P] = 3'd7; en = '1; thr = '0;
    settle();
    chk("R9 source0 id", int'(cid[0 +: IW]), 0);
    chk("R9 source0 irq", int'(irq[0]), 0);
    claim(0, "R9 claim on source0");

    // R4 R5: claim everything in order on context 0
    @(negedge clk);
    lvl = '1;
    for (int s = 0; s < N; s++) prio[s*P +: P] = 3'd1;
    settle();
    for (int i = 0; i < N; i++) begin
      claim(0, "R4 successive claims");
      settle();
      chk_ctx(0, "R4 claimed masked ctx0");
      chk_ctx(1, "R4 claimed masked ctx1");
    end
    claim(1, "R5 empty claim");
    settle();
    chk_ctx(1, "R5 nothing changed");

    // R7: out-of-range completes are ignored
    for (int id = N; id < 16; id++) begin
      complete(0, id);
      settle();
      chk_ctx(0, "R7 out-of-range complete");
    end
    complete(1, 5);
    settle();
    chk_ctx(0, "R7 complete frees 5");
    chk("R7 id is 5", int'(cid[0 +: IW]), 5);

    // R8: claim and complete on the same source in one cycle
    claim_complete(0, 5, "R8 claim sees pre-state");
    settle();
    chk_ctx(0, "R8 complete wins free");
    claim(0, "R8 plain claim of 5");
    claim_complete(0, 5, "R8 claim sees claimed 5");
    settle();
    chk_ctx(0, "R8 complete wins after claimed");

    // R6: pending follows level
    for (int s = 1; s < N; s++) complete(0, s);
    @(negedge clk);
    lvl[1] = 1'b0; lvl[2] = 1'b0;
    settle();
    chk_ctx(0, "R6 low level drops pending");
    @(negedge clk);
    lvl[2] = 1'b1;
    settle();
    chk_ctx(0, "R6 high level sets pending");
    claim(0, "R6 claim takes 2");
    settle();
    chk_ctx(0, "R6 after claim");
    complete(0, 2);
    settle();
    chk_ctx(0, "R6 level still high repends");

    // R10: reset clears claimed state
    claim(0, "R10 claim before reset");
    do_reset();
    settle();
    chk_ctx(0, "R10 claimed cleared by reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule